// File: doc/BRIEF.md
# Single-Error-Correcting Packet Word Codec with Fast Marker Path

The block is a purely combinational encoder and decoder for a packet storage word: 128 payload bits plus three packet markers (start, end and error). Eight check bits protect all of it, the same number a plain 128-bit single-error-correcting code needs, so the stored codeword is 139 bits wide. The encoder side turns a payload and marker set into the eight check bits. The decoder side takes a stored word, which may be corrupted, and returns the corrected payload, the corrected markers and a flag that goes high whenever the word was not clean.

The check bits fall into two groups. The low three form a shared group that covers both markers and payload. The upper five form a group that covers payload only. Each marker uses a column that is zero in the payload-only group. A marker is therefore repaired by looking at the three shared syndrome bits alone, which keeps the marker outputs several logic levels shallower than the payload outputs. This suits read logic where the markers feed a downstream state machine. A double error can miscorrect a marker; single errors are always repaired.

Codeword layout, used on both sides: bits 127..0 are payload, bits 130..128 are markers 2..0, and bits 138..131 are check bits 7..0. Syndrome or check bit k is called c[k]. The shared group is c[2:0] and the payload-only group is c[7:3].

Top module: `sec_fast_codec`

## Requirements
- R1: The encoder output `enc_chk_o` is the XOR of the 8-bit columns of every set payload and marker bit, using the columns of R2 and R3. An all-zero input gives all-zero check bits.
- R2: Marker j uses a column with the payload-only group zero. Its shared group is 3'b011 for j=0, 3'b101 for j=1 and 3'b110 for j=2, so the marker columns are 8'h03, 8'h05 and 8'h06.
- R3: Payload columns are assigned in order of payload index. Shared patterns are walked in the order 000, 001, 010, 100, 111. Under each shared pattern, the payload-only value is walked upward from 0. A combination is skipped if the shared pattern is 000 and the payload-only value has weight 0 or 1, or if the shared pattern has weight 1 and the payload-only value is 0. This gives payload bit 0 the column 8'h18 and payload bit 127 the column 8'h47.
- R4: For a stored word with a zero syndrome, the payload and markers pass through unchanged and `dec_err_o` stays low.
- R5: A single flipped payload bit, at any of the 128 positions, is corrected, and `dec_err_o` goes high.
- R6: A single flipped marker bit is corrected, and `dec_err_o` goes high. A marker output is inverted exactly when the three shared syndrome bits equal that marker's shared pattern; the other five syndrome bits are not consulted.
- R7: A single flipped check bit leaves the payload and marker outputs equal to the stored values, and `dec_err_o` goes high.
- R8: `dec_err_o` is high exactly when the 8-bit syndrome is nonzero. When it is low, no output bit is altered.
- R9: For any input, at most one payload or marker bit is inverted on the way to the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| enc_data_i | input | 128 | Payload to be encoded |
| enc_ctl_i | input | 3 | Markers to be encoded (bit 0 start, bit 1 end, bit 2 error) |
| enc_chk_o | output | 8 | Check bits for the encoder inputs |
| dec_data_i | input | 128 | Stored payload, possibly corrupted |
| dec_ctl_i | input | 3 | Stored markers, possibly corrupted |
| dec_chk_i | input | 8 | Stored check bits, possibly corrupted |
| dec_data_o | output | 128 | Corrected payload |
| dec_ctl_o | output | 3 | Corrected markers |
| dec_err_o | output | 1 | High when the stored word has a nonzero syndrome |

## Verification
The decoder assertions accept any stored word. They do not assume at most one flipped bit: each one states something that also holds under multiple errors, such as one bit altered at most, no alteration for a weight-one syndrome, and a marker altered only when the shared syndrome has weight two. They are skipped while any decoder input is unknown. The stimulus builds each stored word from a correctly encoded word with no flip or exactly one flip, because only those cases have an exactly predictable output. Directed words that set a single payload or marker bit pin down the column assignment at both ends of the payload.

// File: rtl/sec_fast_pkg.sv
package sec_fast_pkg;

    parameter int DATA_W = 128;             // payload bits
    parameter int CTL_W  = 3;               // marker bits
    parameter int SH_W   = 3;               // shared check group
    parameter int DO_W   = 5;               // payload-only check group

    localparam int CHK_W  = SH_W + DO_W;
    localparam int SH_N   = 1 << SH_W;
    localparam int DO_N   = 1 << DO_W;
    localparam int WORD_W = DATA_W + CTL_W + CHK_W;

    // Shared pattern of marker j: the j-th weight-two value in ascending order.
    function automatic logic [SH_W-1:0] ctl_pat(input int j);
        logic [SH_W-1:0] res;
        int n;
        res = '0;
        n   = 0;
        for (int v = 0; v < SH_N; v++) begin
            if ($countones(v) == 2) begin
                if (n == j) res = SH_W'(v);
                n++;
            end
        end
        return res;
    endfunction

    function automatic bit is_ctl_pat(input int v);
        bit hit;
        hit = 1'b0;
        for (int j = 0; j < CTL_W; j++) begin
            if (int'(ctl_pat(j)) == v) hit = 1'b1;
        end
        return hit;
    endfunction

    // Column of payload bit idx: {payload-only group, shared group}.
    function automatic logic [CHK_W-1:0] data_col(input int idx);
        logic [CHK_W-1:0] res;
        int  n;
        bit  bad;
        res = '0;
        n   = 0;
        for (int s = 0; s < SH_N; s++) begin
            if (!is_ctl_pat(s)) begin
                for (int d = 0; d < DO_N; d++) begin
                    bad = ((s == 0) && ($countones(d) <= 1)) ||
                          (($countones(s) == 1) && (d == 0));
                    if (!bad) begin
                        if (n == idx) res = {DO_W'(d), SH_W'(s)};
                        n++;
                    end
                end
            end
        end
        return res;
    endfunction

    // Which payload bits feed check bit k.
    function automatic logic [DATA_W-1:0] data_mask(input int k);
        logic [DATA_W-1:0] m;
        logic [CHK_W-1:0]  c;
        m = '0;
        for (int i = 0; i < DATA_W; i++) begin
            c    = data_col(i);
            m[i] = c[k];
        end
        return m;
    endfunction

    // Which marker bits feed check bit k (only shared bits can be set).
    function automatic logic [CTL_W-1:0] ctl_mask(input int k);
        logic [CTL_W-1:0] m;
        logic [SH_W-1:0]  p;
        m = '0;
        for (int j = 0; j < CTL_W; j++) begin
            p    = ctl_pat(j);
            m[j] = (k < SH_W) ? p[k] : 1'b0;
        end
        return m;
    endfunction

endpackage

// File: rtl/sec_fast_parity.sv
module sec_fast_parity
    import sec_fast_pkg::*;
(
    input  logic [DATA_W-1:0] data_i,
    input  logic [CTL_W-1:0]  ctl_i,
    output logic [CHK_W-1:0]  par_o
);

    // One XOR tree per check bit over its masked inputs.
    for (genvar k = 0; k < CHK_W; k++) begin : g_chk
        localparam logic [DATA_W-1:0] DMASK = data_mask(k);
        localparam logic [CTL_W-1:0]  CMASK = ctl_mask(k);
        assign par_o[k] = (^(data_i & DMASK)) ^ (^(ctl_i & CMASK));
    end

endmodule

// File: rtl/sec_fast_ctl_fix.sv
module sec_fast_ctl_fix
    import sec_fast_pkg::*;
(
    input  logic [SH_W-1:0]  syn_sh_i,
    input  logic [CTL_W-1:0] ctl_i,
    output logic [CTL_W-1:0] ctl_o
);

    // Shallow path: each marker looks at the shared syndrome slice only.
    for (genvar j = 0; j < CTL_W; j++) begin : g_ctl
        localparam logic [SH_W-1:0] PAT = ctl_pat(j);
        assign ctl_o[j] = ctl_i[j] ^ (syn_sh_i == PAT);
    end

endmodule

// File: rtl/sec_fast_data_fix.sv
module sec_fast_data_fix
    import sec_fast_pkg::*;
(
    input  logic [CHK_W-1:0]  syn_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] data_o
);

    // Payload bits need a full 8-bit match of their column.
    for (genvar i = 0; i < DATA_W; i++) begin : g_dat
        localparam logic [CHK_W-1:0] COL = data_col(i);
        assign data_o[i] = data_i[i] ^ (syn_i == COL);
    end

endmodule

// File: rtl/sec_fast_codec.sv
module sec_fast_codec
    import sec_fast_pkg::*;
(
    input  logic [DATA_W-1:0] enc_data_i,
    input  logic [CTL_W-1:0]  enc_ctl_i,
    output logic [CHK_W-1:0]  enc_chk_o,
    input  logic [DATA_W-1:0] dec_data_i,
    input  logic [CTL_W-1:0]  dec_ctl_i,
    input  logic [CHK_W-1:0]  dec_chk_i,
    output logic [DATA_W-1:0] dec_data_o,
    output logic [CTL_W-1:0]  dec_ctl_o,
    output logic              dec_err_o
);

    logic [CHK_W-1:0] dec_par;
    logic [CHK_W-1:0] dec_syn;

    sec_fast_parity u_enc_par (
        .data_i (enc_data_i),
        .ctl_i  (enc_ctl_i),
        .par_o  (enc_chk_o)
    );

    sec_fast_parity u_dec_par (
        .data_i (dec_data_i),
        .ctl_i  (dec_ctl_i),
        .par_o  (dec_par)
    );

    assign dec_syn = dec_par ^ dec_chk_i;

    sec_fast_ctl_fix u_ctl_fix (
        .syn_sh_i (dec_syn[SH_W-1:0]),
        .ctl_i    (dec_ctl_i),
        .ctl_o    (dec_ctl_o)
    );

    sec_fast_data_fix u_data_fix (
        .syn_i  (dec_syn),
        .data_i (dec_data_i),
        .data_o (dec_data_o)
    );

    assign dec_err_o = |dec_syn;

endmodule

// File: rtl/sec_fast_codec_chk.sv
module sec_fast_codec_chk
    import sec_fast_pkg::*;
(
    input logic [DATA_W-1:0] dec_data_i,
    input logic [CTL_W-1:0]  dec_ctl_i,
    input logic [CHK_W-1:0]  dec_chk_i,
    input logic [DATA_W-1:0] dec_data_o,
    input logic [CTL_W-1:0]  dec_ctl_o,
    input logic              dec_err_o,
    input logic [CHK_W-1:0]  syn_i
);

    logic [DATA_W+CTL_W-1:0] flips;
    assign flips = {dec_data_o ^ dec_data_i, dec_ctl_o ^ dec_ctl_i};

    always_comb begin
        if (!$isunknown({dec_data_i, dec_ctl_i, dec_chk_i})) begin
            AST_CLEAN_PASS: assert (syn_i != '0 || (flips == '0 && !dec_err_o))
                else $error("clean word altered or flagged"); // R4
            AST_FLAG_SILENT: assert (dec_err_o || flips == '0)
                else $error("output altered without flag"); // R8
            AST_CHECK_ONLY: assert ($countones(syn_i) != 1 || flips == '0)
                else $error("check-bit syndrome altered output"); // R7
            AST_ONE_FLIP: assert ($countones(flips) <= 1)
                else $error("more than one output bit altered"); // R9
            AST_CTL_SHARED: assert (dec_ctl_o == dec_ctl_i || $countones(syn_i[SH_W-1:0]) == 2)
                else $error("marker altered without weight-two shared syndrome"); // R6
        end
    end

endmodule

bind sec_fast_codec sec_fast_codec_chk u_chk (
    .dec_data_i (dec_data_i),
    .dec_ctl_i  (dec_ctl_i),
    .dec_chk_i  (dec_chk_i),
    .dec_data_o (dec_data_o),
    .dec_ctl_o  (dec_ctl_o),
    .dec_err_o  (dec_err_o),
    .syn_i      (dec_syn)
);

// File: tb/sec_fast_codec_tb_top.sv
`timescale 1ns/1ps
module sec_fast_codec_tb_top;

    localparam int DW = 128;
    localparam int CW = 3;
    localparam int KW = 8;
    localparam int NW = DW + CW + KW;

    logic clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic [DW-1:0] enc_data_i, dec_data_i, dec_data_o;
    logic [CW-1:0] enc_ctl_i, dec_ctl_i, dec_ctl_o;
    logic [KW-1:0] enc_chk_o, dec_chk_i;
    logic          dec_err_o;

    sec_fast_codec dut_i (
        .enc_data_i (enc_data_i),
        .enc_ctl_i  (enc_ctl_i),
        .enc_chk_o  (enc_chk_o),
        .dec_data_i (dec_data_i),
        .dec_ctl_i  (dec_ctl_i),
        .dec_chk_i  (dec_chk_i),
        .dec_data_o (dec_data_o),
        .dec_ctl_o  (dec_ctl_o),
        .dec_err_o  (dec_err_o)
    );

    int errs   = 0;
    int checks = 0;
    bit done   = 0;

    // Column table by codeword position, built from R2/R3 and unit check columns.
    logic [KW-1:0] col [NW];

    initial begin
        int n;
        int shp [5];
        n = 0;
        shp[0] = 0; shp[1] = 1; shp[2] = 2; shp[3] = 4; shp[4] = 7;
        for (int a = 0; a < 5; a++) begin
            for (int d = 0; d < 32; d++) begin
                bit skip;
                skip = (shp[a] == 0 && $countones(d) <= 1) ||
                       ($countones(shp[a]) == 1 && d == 0);
                if (!skip && n < DW) begin
                    col[n] = {d[4:0], shp[a][2:0]};
                    n++;
                end
            end
        end
        col[DW+0] = 8'h03;
        col[DW+1] = 8'h05;
        col[DW+2] = 8'h06;
        for (int k = 0; k < KW; k++) col[DW+CW+k] = 8'(1 << k);
    end

    function automatic logic [KW-1:0] exp_chk(input logic [DW-1:0] d, input logic [CW-1:0] c);
        logic [KW-1:0] acc;
        acc = '0;
        for (int i = 0; i < DW; i++) if (d[i]) acc ^= col[i];
        for (int j = 0; j < CW; j++) if (c[j]) acc ^= col[DW+j];
        return acc;
    endfunction

    task automatic chk8(input string tag, input logic [KW-1:0] act, input logic [KW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Decode a stored word and compare against the intended word.
    task automatic dec_check(input string tag, input logic [NW-1:0] cw,
                             input logic [DW-1:0] d, input logic [CW-1:0] c, input logic e);
        @(posedge clk);
        dec_data_i = cw[DW-1:0];
        dec_ctl_i  = cw[DW+CW-1:DW];
        dec_chk_i  = cw[NW-1:DW+CW];
        @(negedge clk);
        checks++;
        if (dec_data_o !== d || dec_ctl_o !== c || dec_err_o !== e) begin
            errs++;
            $display("FAIL %s act=%h/%h/%b exp=%h/%h/%b", tag,
                     dec_data_o, dec_ctl_o, dec_err_o, d, c, e);
        end
    endtask

    task automatic run_word(input logic [DW-1:0] d, input logic [CW-1:0] c);
        logic [KW-1:0] k;
        logic [NW-1:0] cw;
        @(posedge clk);
        enc_data_i = d;
        enc_ctl_i  = c;
        @(negedge clk);
        k = exp_chk(d, c);
        chk8("R1 encoder", enc_chk_o, k);
        cw = {k, c, d};
        dec_check("R4 clean word", cw, d, c, 1'b0);
        for (int p = 0; p < NW; p++) begin
            logic [NW-1:0] bad;
            bad = cw;
            bad[p] = ~bad[p];
            if (p < DW)           dec_check("R5 payload flip", bad, d, c, 1'b1);
            else if (p < DW + CW) dec_check("R6 marker flip", bad, d, c, 1'b1);
            else                  dec_check("R7 check flip", bad, d, c, 1'b1);
        end
    endtask

    initial begin
        repeat (30000) @(posedge clk);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog act=running exp=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] d;
        void'($urandom(32'd1234));
        enc_data_i = '0; enc_ctl_i = '0;
        dec_data_i = '0; dec_ctl_i = '0; dec_chk_i = '0;
        #1;
        // Idle state: all-zero inputs.
        @(negedge clk);
        chk8("R1 zero word", enc_chk_o, 8'h00);
        chk8("R8 zero syndrome flag", {7'd0, dec_err_o}, 8'h00);

        // Directed column checks.
        @(posedge clk); enc_data_i = '0; enc_data_i[0] = 1'b1; enc_ctl_i = '0;
        @(negedge clk); chk8("R3 payload bit 0 column", enc_chk_o, 8'h18);
        @(posedge clk); enc_data_i = '0; enc_data_i[127] = 1'b1;
        @(negedge clk); chk8("R3 payload bit 127 column", enc_chk_o, 8'h47);
        @(posedge clk); enc_data_i = '0; enc_ctl_i = 3'b001;
        @(negedge clk); chk8("R2 marker 0 column", enc_chk_o, 8'h03);
        @(posedge clk); enc_ctl_i = 3'b010;
        @(negedge clk); chk8("R2 marker 1 column", enc_chk_o, 8'h05);
        @(posedge clk); enc_ctl_i = 3'b100;
        @(negedge clk); chk8("R2 marker 2 column", enc_chk_o, 8'h06);

        // Full words: directed corners then random.
        run_word('0, 3'b000);
        run_word('1, 3'b111);
        run_word({64{2'b10}}, 3'b101);
        for (int w = 0; w < 20; w++) begin
            for (int q = 0; q < 4; q++) d[q*32 +: 32] = $urandom;
            run_word(d, 3'($urandom));
        end

        // R9: flip of payload and marker together must not alter two outputs:
        // shared syndrome of bit 0 (000) xor marker 0 (011) -> no full payload match
        // at the marker side only; outputs may miscorrect one bit at most (checked by
        // assertion), bench only confirms the flag is raised.
        @(posedge clk);
        dec_data_i = '0; dec_data_i[0] = 1'b1; dec_ctl_i = 3'b001; dec_chk_i = '0;
        @(negedge clk);
        chk8("R8 double error flagged", {7'd0, dec_err_o}, 8'h01);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule